// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the serial clock of a SPI master from the system clock. Two stages are chained. An even-only prescaler fires a stride pulse every `pre/2` system cycles. A post-divider counts `1 + post` of those strides for each half-period of the serial clock. The total division from system clock to serial clock is therefore `(1 + post) * pre`. Only even ratios can be produced, from 2 up to 256 * 254.

Along with the serial clock level, the block gives the shift engine two single-cycle strobes. One marks every edge of the serial clock (a half-period boundary). The other marks the completion of each full period, which is when the clock returns to its idle level. The divider settings and the idle polarity are captured on the rising edge of the enable. Changes made while enabled wait for the next enable. While disabled, the counters are cleared and the clock rests at the polarity level.

Top module: `spi_sclk_gen`

## Requirements
- R1: For an even prescale value `p` (2..254) and post value `q` (0..255), successive `half_tick` pulses are exactly `(1+q)*p/2` system cycles apart, so a full serial clock period is `(1+q)*p` cycles.
- R2: An odd prescale value has its least significant bit cleared before use (for example, 7 behaves as 6).
- R3: A prescale value of 0 or 1 behaves as 2.
- R4: On the clock edge that first samples `en` high, the captured polarity drives `sclk`. The first `half_tick` then comes exactly one half-period after that edge.
- R5: `sclk` inverts on exactly those cycles where `half_tick` is high, and holds its value otherwise while enabled.
- R6: `full_tick` is high on every second `half_tick` (the 2nd, 4th, ...), which is when `sclk` returns to the captured polarity level, and never at any other time.
- R7: Reset drives `sclk`, `half_tick` and `full_tick` to 0. One cycle after `en` is sampled low, `sclk` equals `cpol` and both ticks are 0. A new enable then restarts both counters from zero.
- R8: Changes to `pre_div`, `post_div` or `cpol` while `en` stays high do not alter the period or the level pattern until the next enable.
- R9: The largest setting (prescale 254, post 255) gives a half-period of 32512 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; rising edge captures the settings |
| cpol | input | 1 | Idle polarity of the serial clock |
| pre_div | input | PRE_W | Prescale setting (even, 2..254 meaningful) |
| post_div | input | POST_W | Post-divide setting (0..255) |
| sclk | output | 1 | Serial clock level |
| half_tick | output | 1 | One-cycle strobe on every serial clock edge |
| full_tick | output | 1 | One-cycle strobe when a full period completes |

## Verification
The hardest situation to reach from the ports is a settings change arriving in the middle of a run. The counters must ignore it, and the effect is visible only as a period that stays the same. The bench runs with a small period and rewrites all three setting inputs a few cycles after enabling. It then checks that the tick spacing and level pattern still match the settings in force at enable. A second hard case is a disable in the middle of a half-period. The bench drops the enable part-way through a half-period and checks that the next run waits a full half-period before its first edge. The prescale normalisation and ratio arithmetic are covered by a sweep of every prescale value 0..15 against post values 0..3 in both polarities. One run at the largest setting covers the top end of the range.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    // Default field widths for the divider settings
    localparam int DEF_PRE_W  = 8;
    localparam int DEF_POST_W = 8;

    // Strobe bundle presented to the shift engine
    typedef struct packed {
        logic half;
        logic full;
    } tick_t;

    localparam tick_t TICK_NONE = '{half: 1'b0, full: 1'b0};

endpackage

// File: rtl/spi_sclk_cfg.sv
module spi_sclk_cfg #(
    parameter int PRE_W  = spi_sclk_pkg::DEF_PRE_W,
    parameter int POST_W = spi_sclk_pkg::DEF_POST_W,
    localparam int HW    = PRE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol_in,
    input  logic [PRE_W-1:0]  pre_in,
    input  logic [POST_W-1:0] post_in,
    output logic              run,
    output logic              active,
    output logic [HW-1:0]     half_max,
    output logic [POST_W-1:0] post_max,
    output logic              cpol_lat
);

    typedef struct packed {
        logic              run;
        logic [HW-1:0]     hmax;
        logic [POST_W-1:0] post;
        logic              cpol;
    } cfg_state_t;

    cfg_state_t s_d, s_q;
    logic [PRE_W-1:0] pre_even;

    always_comb begin
        s_d      = s_q;
        s_d.run  = en;
        pre_even = {pre_in[PRE_W-1:1], 1'b0};
        if (pre_even < PRE_W'(2)) begin
            pre_even = PRE_W'(2);
        end
        if (en && !s_q.run) begin
            s_d.hmax = pre_even[PRE_W-1:1] - HW'(1);
            s_d.post = post_in;
            s_d.cpol = cpol_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign run      = s_q.run;
    assign active   = en && s_q.run;
    assign half_max = s_q.hmax;
    assign post_max = s_q.post;
    assign cpol_lat = s_q.cpol;

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && $past(s_q.run)) |-> ($stable(s_q.hmax) && $stable(s_q.post) && $stable(s_q.cpol)));

endmodule

// File: rtl/spi_sclk_prescaler.sv
module spi_sclk_prescaler #(
    parameter int PRE_W = spi_sclk_pkg::DEF_PRE_W,
    localparam int HW   = PRE_W - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic [HW-1:0] half_max,
    output logic          stride
);

    typedef struct packed {
        logic [HW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        stride = active && (s_q.cnt == half_max);
        if (!active || stride) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + HW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R1
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (s_q.cnt <= half_max));

    // R7
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> (s_q.cnt == '0));

endmodule

// File: rtl/spi_sclk_postdiv.sv
module spi_sclk_postdiv #(
    parameter int POST_W = spi_sclk_pkg::DEF_POST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              stride,
    input  logic [POST_W-1:0] post_max,
    output logic              edge_evt
);

    typedef struct packed {
        logic [POST_W-1:0] cnt;
    } post_state_t;

    post_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        edge_evt = stride && (s_q.cnt == post_max);
        if (!active || edge_evt) begin
            s_d.cnt = '0;
        end else if (stride) begin
            s_d.cnt = s_q.cnt + POST_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R1
    post_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (s_q.cnt <= post_max));

    // R7
    post_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(active) |-> (s_q.cnt == '0));

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
    parameter int PRE_W  = spi_sclk_pkg::DEF_PRE_W,
    parameter int POST_W = spi_sclk_pkg::DEF_POST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic [PRE_W-1:0]  pre_div,
    input  logic [POST_W-1:0] post_div,
    output logic              sclk,
    output logic              half_tick,
    output logic              full_tick
);

    import spi_sclk_pkg::*;

    localparam int HW = PRE_W - 1;

    typedef struct packed {
        logic  sclk;
        tick_t tick;
    } out_state_t;

    logic              run, active, cpol_lat, stride, edge_evt;
    logic [HW-1:0]     half_max;
    logic [POST_W-1:0] post_max;
    out_state_t        s_d, s_q;

    spi_sclk_cfg #(.PRE_W(PRE_W), .POST_W(POST_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cpol_in  (cpol),
        .pre_in   (pre_div),
        .post_in  (post_div),
        .run      (run),
        .active   (active),
        .half_max (half_max),
        .post_max (post_max),
        .cpol_lat (cpol_lat)
    );

    spi_sclk_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .half_max (half_max),
        .stride   (stride)
    );

    spi_sclk_postdiv #(.POST_W(POST_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .stride   (stride),
        .post_max (post_max),
        .edge_evt (edge_evt)
    );

    always_comb begin
        s_d      = s_q;
        s_d.tick = TICK_NONE;
        if (!en || !run) begin
            // idle, or the enable edge that captures the polarity
            s_d.sclk = cpol;
        end else if (edge_evt) begin
            s_d.sclk      = ~s_q.sclk;
            s_d.tick.half = 1'b1;
            s_d.tick.full = (s_q.sclk != cpol_lat);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk      = s_q.sclk;
    assign half_tick = s_q.tick.half;
    assign full_tick = s_q.tick.full;

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ((sclk == $past(cpol)) && !half_tick && !full_tick));

    // R5
    toggle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && $past(run)) |-> (half_tick == (sclk != $past(sclk))));

    // R6
    full_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_tick |-> (half_tick && (sclk == cpol_lat)));

    // R4
    start_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !run) |=> ((sclk == $past(cpol)) && !half_tick));

endmodule

// File: tb/spi_sclk_gen_bench.sv
module spi_sclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cpol = 1'b0;
    logic [7:0] pre_div = 8'd2;
    logic [7:0] post_div = 8'd0;
    logic       sclk, half_tick, full_tick;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_sclk_gen u_spi_sclk_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cpol      (cpol),
        .pre_div   (pre_div),
        .post_div  (post_div),
        .sclk      (sclk),
        .half_tick (half_tick),
        .full_tick (full_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic int half_len(input int pre, input int post);
        int pe;
        pe = pre - (pre % 2);
        if (pe < 2) pe = 2;
        return (1 + post) * pe / 2;
    endfunction

    // Run one enabled session and check nhalf serial clock edges.
    task automatic run_cfg(input int pre, input int post, input bit cp,
                           input int nhalf, input string tag, input bit scramble);
        int n, cyc, k;
        n = half_len(pre, post);
        @(negedge clk);
        en = 1'b0;
        cpol = cp;
        @(posedge clk); #1;
        check(sclk == cp && !half_tick && !full_tick, "R7", sclk, cp);
        @(negedge clk);
        pre_div = 8'(pre);
        post_div = 8'(post);
        en = 1'b1;
        @(posedge clk); #1;
        check(sclk == cp && !half_tick, "R4", sclk, cp);
        cyc = 0;
        k = 0;
        while (k < nhalf) begin
            @(posedge clk); #1;
            cyc++;
            if (scramble && cyc == 2) begin
                pre_div = 8'd200;
                post_div = 8'd100;
                cpol = ~cp;
            end
            if (half_tick) begin
                k++;
                check(cyc == k * n, tag, cyc, k * n);
                check(sclk == (cp ^ k[0]), "R5", sclk, cp ^ k[0]);
                check(full_tick == !k[0], "R6", full_tick, !k[0]);
            end else begin
                if (full_tick) check(1'b0, "R6", 1, 0);
                if (cyc > (k + 1) * n) begin
                    check(1'b0, tag, cyc, (k + 1) * n);
                    k = nhalf;
                end
            end
        end
        @(negedge clk);
        en = 1'b0;
        cpol = cp;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R7 reset state
        check(sclk == 1'b0 && !half_tick && !full_tick, "R7", sclk, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Sweep prescale 0..15, post 0..3, both polarities
        for (int p = 0; p < 16; p++) begin
            for (int q = 0; q < 4; q++) begin
                for (int c = 0; c < 2; c++) begin
                    run_cfg(p, q, c[0], 3,
                            (p < 2) ? "R3" : (p % 2 == 1) ? "R2" : "R1", 1'b0);
                end
            end
        end

        // R8: settings rewritten mid-run are ignored
        run_cfg(4, 2, 1'b0, 4, "R8", 1'b1);
        run_cfg(6, 1, 1'b1, 4, "R8", 1'b1);

        // R7: disable in the middle of a half-period, restart counts from zero
        @(negedge clk);
        pre_div = 8'd8;
        post_div = 8'd1;
        cpol = 1'b0;
        en = 1'b1;
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        cpol = 1'b1;
        @(posedge clk); #1;
        check(sclk == 1'b1 && !half_tick, "R7", sclk, 1);
        run_cfg(8, 1, 1'b0, 2, "R7", 1'b0);

        // R1 with larger even values
        run_cfg(254, 0, 1'b0, 2, "R1", 1'b0);
        run_cfg(2, 255, 1'b1, 2, "R1", 1'b0);

        // R9: largest ratio
        run_cfg(254, 255, 1'b0, 2, "R9", 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule